// File: doc/BRIEF.md
# Address/Value Serial Frame Transmitter

This block sits on the host side of a three-wire serial link (chip select, serial clock, serial data) that loads one register of a multichannel register bank per frame. The host logic gives it a 4-bit channel address and an 8-bit value, together with a one-cycle start strobe. The block returns a busy level while it works and a one-cycle done pulse when the frame is complete. The frame goes out most significant bit first. The receiver samples data on the rising serial clock edge and commits the update when chip select rises.

A mode input picks the frame shape. The compact shape is 12 bits: the address nibble followed by the data byte. The byte-aligned shape is 16 bits: four zero bits come first, then the address nibble and the data byte. The byte-aligned shape suits hosts that only think in bytes, because the receiver keeps only the last 12 bits it has shifted in.

The serial clock is made from the system clock by a programmable phase length. The clock idles high, and chip select changes only while the clock is high. After every frame, chip select is held high for a programmable guard interval before a new start is accepted.

Top module: `trim_serial_tx`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 1, busy_o is 0 and done_o is 0.
- R2: With wide_i = 0 at the accepted start, exactly 12 rising sclk_o edges occur while cs_n_o is low. The sdo_o values sampled on those edges are addr_i[3] down to addr_i[0], then value_i[7] down to value_i[0].
- R3: With wide_i = 1 at the accepted start, exactly 16 rising sclk_o edges occur while cs_n_o is low. The sampled bits are four zeros, then addr_i[3..0], then value_i[7..0], each field MSB first.
- R4: cs_n_o falls and rises only in cycles where sclk_o is 1. While cs_n_o is high, sclk_o is 1.
- R5: While cs_n_o is low, sdo_o does not change across consecutive cycles in which sclk_o stays high. Data changes only in the cycle in which sclk_o goes low.
- R6: Every high phase and every low phase of sclk_o inside a frame lasts exactly half_div_i + 1 system clock cycles. This includes the high phase between the fall of cs_n_o and the first falling clock edge, and the high phase before cs_n_o rises.
- R7: start_i is accepted only in a cycle where busy_o is 0. A start pulse while busy_o is 1 starts no extra frame.
- R8: busy_o rises in the cycle after an accepted start and is 1 whenever cs_n_o is 0. done_o is a single-cycle pulse in the first cycle in which cs_n_o is high again after a frame.
- R9: After cs_n_o rises, busy_o stays 1 for exactly gap_i + 1 cycles (including the rise cycle). Only then is a new start accepted.
- R10: addr_i, value_i and wide_i are captured at the accepted start. Changing them during a frame does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to send one frame; used only while idle |
| addr_i | input | 4 | Channel address to send |
| value_i | input | 8 | Data byte to send |
| wide_i | input | 1 | 1 selects the 16-bit zero-padded frame, 0 the 12-bit frame |
| half_div_i | input | 8 | Serial clock phase length minus one, in system clocks |
| gap_i | input | 8 | Guard interval after a frame minus one, in system clocks |
| busy_o | output | 1 | Frame or guard interval in progress |
| done_o | output | 1 | One-cycle pulse when chip select has risen |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
The properties assume that half_div_i and gap_i stay constant while busy_o is high, because both are reloaded into the phase and guard counters as the frame proceeds. The stimulus changes these two inputs only while the block is idle. It changes the address, value and mode, and raises stray start pulses, in the middle of frames. The properties also assume that rst_n is released away from a start request. The bench keeps start_i low until several cycles after reset is released.

// File: rtl/tx_pkg.sv
package tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_GUARD = 3'd4
  } tx_state_e;

endpackage

// File: rtl/tx_reset_sync.sv
module tx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tx_down_timer.sv
module tx_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int PAD_W   = 4,
  parameter int FRAME_W = ADDR_W + DATA_W + PAD_W,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              sdo_o,
  output logic              last_o
);

  localparam int SHORT_W = ADDR_W + DATA_W;

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic [FRAME_W-1:0] packed_word;
  logic               reg_en;

  always_comb begin
    packed_word = FRAME_W'({addr_i, value_i});
    reg_en      = load_i || shift_i;
    sh_d        = sh_q;
    left_d      = left_q;
    if (load_i) begin
      // Wide frame: zero pad leads. Compact frame: payload left aligned.
      sh_d   = wide_i ? packed_word : (packed_word << PAD_W);
      left_d = wide_i ? CNT_W'(FRAME_W) : CNT_W'(SHORT_W);
    end else if (shift_i) begin
      sh_d   = sh_q << 1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (reg_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign sdo_o  = sh_q[FRAME_W-1];
  assign last_o = (left_q == CNT_W'(1));

endmodule

// File: rtl/trim_serial_tx.sv
module trim_serial_tx
  import tx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              wide_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              sdo_o
);

  localparam int SHORT_W = ADDR_W + DATA_W;
  localparam int PAD_W   = (8 - (SHORT_W % 8)) % 8;
  localparam int FRAME_W = SHORT_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic      rst_i_n;
  tx_state_e state_q, state_d;
  logic      accept, in_frame, ph_zero, ph_load;
  logic      shift_en, g_load, g_zero, last_bit, sh_bit;
  logic      done_q, done_d;

  tx_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tx_down_timer #(.W(DIV_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (ph_load),
    .val_i  (half_div_i),
    .zero_o (ph_zero)
  );

  tx_down_timer #(.W(GAP_W)) u_guard (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (g_load),
    .val_i  (gap_i),
    .zero_o (g_zero)
  );

  tx_frame_shifter #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PAD_W  (PAD_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load_i  (accept),
    .shift_i (shift_en),
    .wide_i  (wide_i),
    .addr_i  (addr_i),
    .value_i (value_i),
    .sdo_o   (sh_bit),
    .last_o  (last_bit)
  );

  // Next-state process
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    shift_en = 1'b0;
    g_load   = 1'b0;
    done_d   = 1'b0;
    in_frame = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept  = 1'b1;
          state_d = ST_LEAD;
        end
      end
      ST_LEAD: if (ph_zero) state_d = ST_LOW;
      ST_LOW:  if (ph_zero) state_d = ST_HIGH;
      ST_HIGH: begin
        if (ph_zero) begin
          if (last_bit) begin
            g_load  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_GUARD;
          end else begin
            shift_en = 1'b1;
            state_d  = ST_LOW;
          end
        end
      end
      ST_GUARD: if (g_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    ph_load = accept || (in_frame && ph_zero);
  end

  // Register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign cs_n_o = !in_frame;
  assign sclk_o = (state_q != ST_LOW);
  assign sdo_o  = in_frame && sh_bit;

endmodule

// File: rtl/tx_serial_chk.sv
module tx_serial_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o
);

  // R4
  csn_fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> sclk_o);

  // R4
  csn_rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> sclk_o);

  // R4
  idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  // R5
  data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && sclk_o && $past(!cs_n_o && sclk_o)) |-> $stable(sdo_o));

  // R7
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(start_i && !busy_o));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && busy_o && $past(!cs_n_o)));

  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

endmodule

bind trim_serial_tx tx_serial_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cs_n_o  (cs_n_o),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o)
);

// File: tb/trim_serial_tx_tb_top.sv
module trim_serial_tx_tb_top;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] addr_i;
  logic [7:0] value_i;
  logic       wide_i;
  logic [7:0] half_div_i;
  logic [7:0] gap_i;
  logic       busy_o, done_o, cs_n_o, sclk_o, sdo_o;

  int checks = 0;
  int errors = 0;
  int frames = 0;
  int dones  = 0;

  logic [15:0] exp_word;
  int          exp_bits;
  logic [15:0] rx_word;
  int          rx_cnt, hi_cnt, lo_cnt, guard_cnt;
  logic        guard_on, armed;
  logic        p_cs, p_sclk, p_sdo, p_busy;

  trim_serial_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .value_i    (value_i),
    .wide_i     (wide_i),
    .half_div_i (half_div_i),
    .gap_i      (gap_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_word(input logic [3:0] a, input logic [7:0] v);
    return {4'b0000, a, v};
  endfunction

  function automatic int frame_bits(input logic w);
    return w ? 16 : 12;
  endfunction

  // Receiver model and timing monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      guard_on <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
      p_cs <= cs_n_o; p_sclk <= sclk_o; p_sdo <= sdo_o; p_busy <= busy_o;
    end else begin
      if (p_cs && !cs_n_o) begin
        chk(sclk_o == 1'b1, "R4 sclk at cs fall", sclk_o, 1);
        rx_word = '0; rx_cnt = 0; hi_cnt = 1; lo_cnt = 0;
      end else if (!cs_n_o) begin
        if (sclk_o && !p_sclk) begin
          chk(lo_cnt == half_div_i + 1, "R6 low phase", lo_cnt, half_div_i + 1);
          rx_word = {rx_word[14:0], sdo_o};
          rx_cnt++;
          hi_cnt = 1;
        end else if (sclk_o && p_sclk) begin
          hi_cnt++;
          chk(sdo_o == p_sdo, "R5 data hold in high phase", sdo_o, p_sdo);
        end else if (!sclk_o && p_sclk) begin
          chk(hi_cnt == half_div_i + 1, "R6 high phase", hi_cnt, half_div_i + 1);
          lo_cnt = 1;
        end else begin
          lo_cnt++;
        end
        chk(busy_o == 1'b1, "R8 busy in frame", busy_o, 1);
      end
      if (!p_cs && cs_n_o) begin
        chk(sclk_o == 1'b1, "R4 sclk at cs rise", sclk_o, 1);
        chk(hi_cnt == half_div_i + 1, "R6 final high phase", hi_cnt, half_div_i + 1);
        chk(rx_cnt == exp_bits, exp_bits == 16 ? "R3 bit count" : "R2 bit count", rx_cnt, exp_bits);
        chk(rx_word == exp_word, exp_bits == 16 ? "R3 frame word" : "R2 frame word", rx_word, exp_word);
        chk(done_o == 1'b1, "R8 done at cs rise", done_o, 1);
        frames++;
        guard_cnt = 1;
        guard_on <= 1'b1;
      end else if (done_o) begin
        chk(1'b0, "R8 stray done", 1, 0);
      end
      if (done_o) dones++;
      if (guard_on && !(!p_cs && cs_n_o)) begin
        if (busy_o) guard_cnt++;
        else begin
          chk(guard_cnt == gap_i + 1, "R9 guard length", guard_cnt, gap_i + 1);
          guard_on <= 1'b0;
        end
      end
      if (cs_n_o) chk(sclk_o == 1'b1, "R4 idle clock high", sclk_o, 1);
      p_cs <= cs_n_o; p_sclk <= sclk_o; p_sdo <= sdo_o; p_busy <= busy_o;
    end
  end

  task automatic send(input logic [3:0] a, input logic [7:0] v, input logic w,
                      input logic [7:0] h, input logic [7:0] g, input bit noise);
    int f0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    f0 = frames;
    half_div_i = h; gap_i = g;
    addr_i = a; value_i = v; wide_i = w;
    exp_word = frame_word(a, v);
    exp_bits = frame_bits(w);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    if (noise) begin
      repeat (3) @(negedge clk);
      // R7 / R10: stray start and new inputs mid-frame must not matter
      addr_i = 4'($urandom); value_i = 8'($urandom); wide_i = 1'($urandom);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk(frames == f0 + 1, "R7 one frame per accepted start", frames, f0 + 1);
    chk(dones == frames, "R8 done count", dones, frames);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; value_i = '0; wide_i = 1'b0;
    half_div_i = 8'd1; gap_i = 8'd2; exp_word = '0; exp_bits = 12;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1, "R1 cs_n reset", cs_n_o, 1);
    chk(sclk_o == 1'b1, "R1 sclk reset", sclk_o, 1);
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // Directed corner cases
    send(4'hF, 8'hFF, 1'b1, 8'd0, 8'd0, 1'b0);   // R3 all ones, fastest clock
    send(4'h0, 8'h00, 1'b0, 8'd0, 8'd0, 1'b0);   // R2 all zeros
    send(4'hA, 8'h5A, 1'b0, 8'd5, 8'd9, 1'b1);   // R2 R7 R10 slow clock, long guard
    send(4'h5, 8'hA5, 1'b1, 8'd2, 8'd1, 1'b1);   // R3 R7 R10
    send(4'hB, 8'h01, 1'b0, 8'd1, 8'd3, 1'b0);   // R6 R9
    // Random frames
    for (int i = 0; i < 40; i++) begin
      send(4'($urandom), 8'($urandom), 1'($urandom), 8'($urandom_range(0, 3)),
           8'($urandom_range(0, 5)), 1'($urandom));
    end
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule